// File: doc/BRIEF.md
# Secure Coprocessor Command Mailbox

This block is a register-mapped mailbox between a host and a secure coprocessor. The host stages a set of argument words through a simple word-addressed register bus. It then writes a command word. The command write is the only event that commits a message: it takes a snapshot of the staged arguments and the command, and places them in a small command queue. The coprocessor drains this queue through a ready/valid pop port.

When the coprocessor finishes a command, it pulses a completion input together with a return value and a set of result words. The block holds these values in read-only registers. The block also records three events in a cause register: completion, a command written into a full queue, and the queue becoming full. Each event can raise a level interrupt unless its mask bit blocks it. Host software uses the queue occupancy field to pace its command writes. It clears handled causes by writing ones to them.

Top module: `cmd_mailbox`

## Requirements
- R1: Argument word i (i = 0..NPARAM-1) is written and read back at byte offset 4*i, and holds its value until it is written again.
- R2: A write to offset 0x40 places the command and a snapshot of the current argument words into the queue. The pop port presents entries in the order they were written. Argument writes made after the commit do not change an entry that is already queued. On the pop port, word i sits at q_params bits 32*i+31 down to 32*i.
- R3: A read of offset 0xC4 returns the pending command count in bits 2:0 and the cop_ready input in bit 8. All other bits read as zero.
- R4: A command write that arrives while the count equals QDEPTH (4) is dropped and leaves the queue unchanged. It also sets cause bit 17.
- R5: Cause bit 18 is set in the cycle in which the pending count reaches QDEPTH. It is not set while the count is below QDEPTH.
- R6: A done_pulse stores done_ret, readable at offset 0x80, and result word i, readable at offset 0x84 + 4*i. It also sets cause bit 0.
- R7: The cause register at offset 0xC8 clears each bit that is written with a 1. If a bit is set by an event and cleared by a write in the same cycle, the set wins.
- R8: The mask register at offset 0xCC resets to all ones. The irq output is the OR of the cause bits whose mask bit is 0, and it stays high until those cause bits are cleared.
- R9: q_valid is high whenever the count is non-zero. Each cycle with both q_valid and q_ready high removes one entry and lowers the count by one. The count never exceeds QDEPTH.
- R10: After reset, the count is 0, the cause register is 0, q_valid is low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cop_ready | input | 1 | Coprocessor ready flag, reflected in the queue status register |
| q_valid | output | 1 | Queue holds at least one command |
| q_ready | input | 1 | Coprocessor takes the head entry |
| q_cmd | output | 32 | Command word of the head entry |
| q_params | output | 32*NPARAM | Argument words of the head entry |
| done_pulse | input | 1 | Command completion strobe |
| done_ret | input | 32 | Return value of the completed command |
| done_status | input | 32*NPARAM | Result words of the completed command |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: sixteen argument words and a queue depth of four. With a depth of four, the full queue, the full cause and the overflow drop can all be reached after a few command writes, and with a distinct argument set per command a stale or misordered snapshot shows up on the pop port. Using sixteen words also exercises the first and last result registers at their fixed offsets, 0x84 and 0xC0.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int NPARAM = 16,
  parameter int QDEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  cop_ready,
  output logic                  q_valid,
  input  logic                  q_ready,
  output logic [31:0]           q_cmd,
  output logic [32*NPARAM-1:0]  q_params,
  input  logic                  done_pulse,
  input  logic [31:0]           done_ret,
  input  logic [32*NPARAM-1:0]  done_status,
  output logic                  irq
);
  localparam int EW = 32 * (NPARAM + 1);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [5:0] IX_CMD  = 6'd16;
  localparam logic [5:0] IX_RET  = 6'd32;
  localparam logic [5:0] IX_STS0 = 6'd33;
  localparam logic [5:0] IX_FIFO = 6'd49;
  localparam logic [5:0] IX_CAUS = 6'd50;
  localparam logic [5:0] IX_MASK = 6'd51;

  logic [31:0]   prm [NPARAM];
  logic [31:0]   sts [NPARAM];
  logic [31:0]   ret_q;
  logic [EW-1:0] qmem [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [2:0]    cause_q;
  logic [31:0]   mask_q;
  logic [32*NPARAM-1:0] prm_flat;

  wire [5:0] idx     = bus_addr[7:2];
  wire       cmd_try = bus_wr && idx == IX_CMD;
  wire       full    = cnt == CW'(QDEPTH);
  wire       push    = cmd_try && !full;
  wire       pop     = q_valid && q_ready;
  wire [CW-1:0] cnt_n = cnt + CW'(push) - CW'(pop);
  wire [2:0] cset = {cnt_n == CW'(QDEPTH) && !full, cmd_try && full, done_pulse};
  wire [2:0] cclr = (bus_wr && idx == IX_CAUS) ? {bus_wdata[18], bus_wdata[17], bus_wdata[0]} : 3'b0;
  wire [31:0] cause32 = {13'b0, cause_q[2], cause_q[1], 16'b0, cause_q[0]};

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < NPARAM; i++) begin : g_prm
    assign prm_flat[32*i +: 32] = prm[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prm[i] <= '0;
        sts[i] <= '0;
      end else begin
        if (bus_wr && idx == 6'(i)) prm[i] <= bus_wdata;
        if (done_pulse) sts[i] <= done_status[32*i +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) qmem[wp] <= {prm_flat, bus_wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      cause_q <= '0;
      mask_q  <= '1;
      ret_q   <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt     <= cnt_n;
      cause_q <= (cause_q & ~cclr) | cset;
      if (bus_wr && idx == IX_MASK) mask_q <= bus_wdata;
      if (done_pulse) ret_q <= done_ret;
    end
  end

  assign q_valid  = cnt != '0;
  assign q_cmd    = qmem[rp][31:0];
  assign q_params = qmem[rp][EW-1:32];
  assign irq      = |(cause32 & ~mask_q);

  always_comb begin
    bus_rdata = '0;
    if (idx < 6'(NPARAM)) bus_rdata = prm[idx[3:0]];
    else if (idx >= IX_STS0 && idx < IX_STS0 + 6'(NPARAM)) bus_rdata = sts[4'(idx - IX_STS0)];
    else begin
      case (idx)
        IX_RET:  bus_rdata = ret_q;
        IX_FIFO: bus_rdata = {23'b0, cop_ready, 5'b0, 3'(cnt)};
        IX_CAUS: bus_rdata = cause32;
        IX_MASK: bus_rdata = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int QDEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          push,
  input logic          pop,
  input logic          cmd_try,
  input logic [2:0]    cause_q,
  input logic [31:0]   mask_q,
  input logic          done_pulse,
  input logic          irq
);
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(QDEPTH)); // R9
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n) pop && !push |=> cnt == $past(cnt) - CW'(1)); // R9
  AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n) cmd_try && cnt == CW'(QDEPTH) && !pop |=> cnt == CW'(QDEPTH) && cause_q[1]); // R4
  AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) cnt == CW'(QDEPTH) && $past(cnt) != CW'(QDEPTH) |-> cause_q[2]); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) done_pulse |=> cause_q[0]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) mask_q[0] && mask_q[17] && mask_q[18] |-> !irq); // R8
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .push(push), .pop(pop), .cmd_try(cmd_try),
  .cause_q(cause_q), .mask_q(mask_q), .done_pulse(done_pulse), .irq(irq)
);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  localparam int NP = 16;
  localparam int QD = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cop_ready = 0, q_valid, q_ready = 0, done_pulse = 0, irq;
  logic [31:0] q_cmd, done_ret = 0;
  logic [32*NP-1:0] q_params, done_status = 0;

  int tests = 0, fails = 0, popped = 0;
  logic [32*NP+31:0] sb[$];

  always #5 clk = ~clk;

  cmd_mailbox #(.NPARAM(NP), .QDEPTH(QD)) u_cmd_mailbox (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic send(input logic [31:0] cmd, input bit expect_q);
    logic [32*NP-1:0] p;
    for (int i = 0; i < NP; i++) begin
      p[32*i +: 32] = {cmd[15:0], 16'(i)};
      wr(8'(4*i), {cmd[15:0], 16'(i)});
    end
    wr(8'h40, cmd);
    if (expect_q) sb.push_back({p, cmd});
  endtask

  always @(negedge clk) begin
    if (rst_n && q_valid && q_ready) begin
      logic [32*NP+31:0] e;
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2 act=%h exp=empty", q_cmd);
      end else begin
        e = sb.pop_front();
        popped++;
        if ({q_params, q_cmd} !== e) begin
          fails++;
          $display("FAIL R2 act=%h exp=%h", q_cmd, e[31:0]);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'hC4, v); chk("R10 count", v, 32'h0);
    rd(8'hC8, v); chk("R10 cause", v, 32'h0);
    rd(8'hCC, v); chk("R8 mask reset", v, 32'hFFFF_FFFF);
    chk("R10 q_valid/irq", {30'b0, q_valid, irq}, 32'h0);

    wr(8'h3C, 32'hA5A5_0F0F);
    rd(8'h3C, v); chk("R1 param 15", v, 32'hA5A5_0F0F);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); chk("R1 param 0", v, 32'h1234_5678);

    send(32'h0000_0101, 1);
    rd(8'hC4, v); chk("R3 count 1", v, 32'h1);
    chk("R9 q_valid", {31'b0, q_valid}, 32'h1);
    cop_ready = 1;
    send(32'h0000_0202, 1);
    send(32'h0000_0303, 1);
    rd(8'hC4, v); chk("R3 count 3 ready", v, 32'h103);
    rd(8'hC8, v); chk("R5 not full yet", v, 32'h0);
    send(32'h0000_0404, 1);
    rd(8'hC4, v); chk("R3 count 4", v, 32'h104);
    rd(8'hC8, v); chk("R5 full cause", v, 32'h0004_0000);
    send(32'h0000_0505, 0);
    rd(8'hC4, v); chk("R4 count held", v, 32'h104);
    rd(8'hC8, v); chk("R4 overflow cause", v, 32'h0006_0000);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(8'hCC, 32'hFFFB_FFFF);
    chk("R8 irq on unmask", {31'b0, irq}, 32'h1);
    wr(8'hC8, 32'h0002_0000);
    rd(8'hC8, v); chk("R7 partial clear", v, 32'h0004_0000);
    chk("R8 irq holds", {31'b0, irq}, 32'h1);
    wr(8'hC8, 32'h0004_0000);
    rd(8'hC8, v); chk("R7 cleared", v, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    @(negedge clk); q_ready = 1;
    repeat (6) @(negedge clk);
    q_ready = 0;
    chk("R2 drained all", 32'(popped), 32'd4);
    chk("R9 empty", {31'b0, q_valid}, 32'h0);
    rd(8'hC4, v); chk("R9 count 0", v, 32'h100);

    for (int i = 0; i < NP; i++) done_status[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
    done_ret = 32'hDEAD_BEEF;
    @(negedge clk); done_pulse = 1;
    @(negedge clk); done_pulse = 0;
    rd(8'h80, v); chk("R6 ret", v, 32'hDEAD_BEEF);
    rd(8'h84, v); chk("R6 status 0", v, 32'hC0DE_0000);
    rd(8'hC0, v); chk("R6 status 15", v, 32'hC0DE_000F);
    rd(8'hC8, v); chk("R6 done cause", v, 32'h1);
    wr(8'hCC, 32'hFFFF_FFFE);
    chk("R8 irq done", {31'b0, irq}, 32'h1);

    @(negedge clk); bus_addr = 8'hC8; bus_wr = 1; bus_wdata = 32'h1; done_pulse = 1;
    @(negedge clk); bus_wr = 0; done_pulse = 0;
    rd(8'hC8, v); chk("R7 set wins", v, 32'h1);
    wr(8'hC8, 32'h1);
    rd(8'hC8, v); chk("R7 w1c", v, 32'h0);
    chk("R8 irq clear", {31'b0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule